// File: doc/BRIEF.md
# DMA Channel-Link Request Router

This block sits beside a small group of DMA channels and lets the progress of one channel wake up others. Each channel reports two events as single-cycle pulses: the end of one cycle-steal unit, and its remaining byte count reaching zero. A per-channel link mode, together with two target indices, decides which other channels (if any) receive an internal request as a result.

Link requests are registered, so a request appears on the target one cycle after the event that caused it. That delay also lets a channel target itself safely. A request is delivered only if the target's request-enable input is high in the event cycle. Otherwise it is discarded and not remembered. The internal link requests are ORed with each channel's peripheral request to form the request that goes on to the channel. There is no streaming data path here, so every pin is a plain level or pulse with no back-pressure.

Link mode encoding, per channel (2 bits):
- 0: no links.
- 1: after every unit, the first target is requested. When the count reaches zero, the second target is requested.
- 2: after every unit, the first target is requested. Nothing happens at the end.
- 3: when the count reaches zero, the first target is requested. Nothing happens per unit.

Top module: `chlink_router`

## Requirements
- R1: After reset, `link_req_o` is all zeros until a link event has been registered.
- R2: A source in mode 0 never raises a link request, whatever its event pulses.
- R3: In mode 1, a unit pulse on a source raises bit `tgt1` of `link_req_o` on the next cycle.
- R4: In mode 1, a count-zero pulse raises bit `tgt2` of `link_req_o` on the next cycle.
- R5: In mode 2, a unit pulse raises bit `tgt1` on the next cycle, and a count-zero pulse has no effect.
- R6: In mode 3, a count-zero pulse raises bit `tgt1` on the next cycle, and a unit pulse has no effect.
- R7: In mode 1, when a unit pulse and a count-zero pulse occur in the same cycle, both `tgt1` and `tgt2` are requested in the same following cycle.
- R8: Each event yields a one-cycle pulse. Requests aimed at the same target from several sources are ORed together.
- R9: A source may name itself as a target and receives its own request on the next cycle.
- R10: A link request to channel t is delivered only if `req_en_i[t]` is high in the event cycle. If it is low, the request is dropped and does not appear later.
- R11: `chan_req_o` equals `periph_req_i` ORed with `link_req_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_mode_i | input | 2*NCH | Link mode per channel, channel c in bits [2c+1:2c] |
| tgt1_i | input | IDXW*NCH | First target index per channel |
| tgt2_i | input | IDXW*NCH | Second target index per channel |
| req_en_i | input | NCH | Request enable per target channel |
| unit_done_i | input | NCH | One-cycle pulse: a cycle-steal unit finished |
| count_zero_i | input | NCH | One-cycle pulse: the byte count reached zero |
| periph_req_i | input | NCH | Peripheral requests per channel |
| link_req_o | output | NCH | Registered internal link requests |
| chan_req_o | output | NCH | Combined request to each channel |

## Verification
The hardest case to reach from the ports is a request that would land on a disabled target, together with proof that it is dropped rather than held. The bench sweeps every source, mode, target pair and event combination while rotating a single cleared enable bit across the targets. For each case it checks the output cycle, then clears the events and checks that the following cycle is silent, which shows that no request was kept back for later. Separate cases cover several sources converging on one target, and a request blocked while its target is disabled that must not appear once the enable returns.

// File: rtl/chlink_pkg.sv
package chlink_pkg;
  typedef enum logic [1:0] {
    LNK_NONE         = 2'd0,
    LNK_UNIT_AND_END = 2'd1,
    LNK_UNIT         = 2'd2,
    LNK_END          = 2'd3
  } link_mode_e;
endpackage

// File: rtl/chlink_decode.sv
// Per-source decoder: turns event pulses plus mode into a one-hot-or-zero
// target vector (up to two bits when both links fire).
module chlink_decode
  import chlink_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [1:0]      mode_i,
  input  logic [IDXW-1:0] tgt1_i,
  input  logic [IDXW-1:0] tgt2_i,
  input  logic            unit_i,
  input  logic            zero_i,
  output logic [NCH-1:0]  hit_o
);
  link_mode_e mode;
  logic fire1, fire2;

  always_comb begin
    mode  = link_mode_e'(mode_i);
    fire1 = 1'b0;
    fire2 = 1'b0;
    unique case (mode)
      LNK_NONE:         ;
      LNK_UNIT_AND_END: begin fire1 = unit_i; fire2 = zero_i; end
      LNK_UNIT:         fire1 = unit_i;
      LNK_END:          fire1 = zero_i;
      default:          ;
    endcase
  end

  for (genvar t = 0; t < NCH; t++) begin : g_tgt
    assign hit_o[t] = (fire1 && (tgt1_i == IDXW'(t))) ||
                      (fire2 && (tgt2_i == IDXW'(t)));
  end
endmodule

// File: rtl/chlink_merge.sv
// Collects hits from all sources per target, gates by enable, registers.
module chlink_merge #(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*NCH-1:0] hits_i,   // source s owns bits [s*NCH +: NCH]
  input  logic [NCH-1:0]     en_i,
  output logic [NCH-1:0]     req_q_o
);
  logic [NCH-1:0] any_hit;

  always_comb begin
    any_hit = '0;
    for (int s = 0; s < NCH; s++) begin
      any_hit = any_hit | hits_i[s*NCH +: NCH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q_o <= '0;
    else        req_q_o <= any_hit & en_i;
  end
endmodule

// File: rtl/chlink_router.sv
module chlink_router #(
  parameter int NCH  = 4,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NCH-1:0]    link_mode_i,
  input  logic [IDXW*NCH-1:0] tgt1_i,
  input  logic [IDXW*NCH-1:0] tgt2_i,
  input  logic [NCH-1:0]      req_en_i,
  input  logic [NCH-1:0]      unit_done_i,
  input  logic [NCH-1:0]      count_zero_i,
  input  logic [NCH-1:0]      periph_req_i,
  output logic [NCH-1:0]      link_req_o,
  output logic [NCH-1:0]      chan_req_o
);
  localparam int HW = NCH * NCH;
  logic [HW-1:0] hits;

  for (genvar s = 0; s < NCH; s++) begin : g_src
    chlink_decode #(.NCH(NCH), .IDXW(IDXW)) u_dec (
      .mode_i (link_mode_i[2*s +: 2]),
      .tgt1_i (tgt1_i[IDXW*s +: IDXW]),
      .tgt2_i (tgt2_i[IDXW*s +: IDXW]),
      .unit_i (unit_done_i[s]),
      .zero_i (count_zero_i[s]),
      .hit_o  (hits[s*NCH +: NCH])
    );
  end

  chlink_merge #(.NCH(NCH)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .hits_i  (hits),
    .en_i    (req_en_i),
    .req_q_o (link_req_o)
  );

  assign chan_req_o = periph_req_i | link_req_o;
endmodule

// File: rtl/chlink_router_chk.sv
module chlink_router_chk #(
  parameter int NCH  = 4,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*NCH-1:0]    link_mode_i,
  input logic [NCH-1:0]      req_en_i,
  input logic [NCH-1:0]      unit_done_i,
  input logic [NCH-1:0]      count_zero_i,
  input logic [NCH-1:0]      periph_req_i,
  input logic [NCH-1:0]      link_req_o,
  input logic [NCH-1:0]      chan_req_o
);
  logic past_valid;
  always_ff @(posedge clk) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R1 / R8: with no event in a cycle, the next cycle carries no link request
  assert_quiet_after_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && ((unit_done_i | count_zero_i) == '0)) |=> (link_req_o == '0));

  // R2: all sources in mode 0 produce nothing on the next cycle
  assert_mode0_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && link_mode_i == '0) |=> (link_req_o == '0));

  // R10: a delivered request needs its target enabled in the event cycle
  for (genvar t = 0; t < NCH; t++) begin : g_en
    assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !req_en_i[t]) |=> !link_req_o[t]);
  end

  // R11: peripheral requests always pass through, and link requests too
  assert_periph_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_req_i | link_req_o) & ~chan_req_o) == '0);
  assert_no_extra_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req_o & ~(periph_req_i | link_req_o)) == '0);
endmodule

bind chlink_router chlink_router_chk #(.NCH(NCH), .IDXW(IDXW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_mode_i  (link_mode_i),
  .req_en_i     (req_en_i),
  .unit_done_i  (unit_done_i),
  .count_zero_i (count_zero_i),
  .periph_req_i (periph_req_i),
  .link_req_o   (link_req_o),
  .chan_req_o   (chan_req_o)
);

// File: tb/chlink_router_bench.sv
module chlink_router_bench;
  localparam int NCH  = 4;
  localparam int IDXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode [NCH];
  logic [1:0] t1 [NCH];
  logic [1:0] t2 [NCH];
  logic [NCH-1:0] en, unit, zero, periph;
  logic [NCH-1:0] link_req, chan_req;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  chlink_router #(.NCH(NCH), .IDXW(IDXW)) u_chlink_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_mode_i  ({mode[3], mode[2], mode[1], mode[0]}),
    .tgt1_i       ({t1[3], t1[2], t1[1], t1[0]}),
    .tgt2_i       ({t2[3], t2[2], t2[1], t2[0]}),
    .req_en_i     (en),
    .unit_done_i  (unit),
    .count_zero_i (zero),
    .periph_req_i (periph),
    .link_req_o   (link_req),
    .chan_req_o   (chan_req)
  );

  task automatic check(input string req, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < NCH; c++) begin
      mode[c] = 2'd0; t1[c] = 2'd0; t2[c] = 2'd0;
    end
    unit = '0; zero = '0; periph = '0; en = '1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    check("R1 reset", link_req, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", link_req, '0);

    // Sweep: source, mode, target pair, event combination, rotating enable
    for (int s = 0; s < NCH; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < NCH; a++) begin
          for (int b = 0; b < NCH; b++) begin
            for (int ev = 1; ev < 4; ev++) begin
              logic [NCH-1:0] exp, raw;
              int k;
              string tag;
              k = ((s*4 + m)*16 + a*4 + b)*3 + ev;
              clear_cfg();
              mode[s] = 2'(m); t1[s] = 2'(a); t2[s] = 2'(b);
              unit[s] = ev[0]; zero[s] = ev[1];
              en = (k % 8 < 4) ? ~(4'b1 << (k % 8)) : 4'hF;
              periph = 4'(k * 7);
              raw = '0;
              if ((m == 1 || m == 2) && ev[0]) raw[a] = 1'b1;
              if (m == 3 && ev[1])             raw[a] = 1'b1;
              if (m == 1 && ev[1])             raw[b] = 1'b1;
              exp = raw & en;
              if (raw != exp)          tag = "R10 gated";
              else if (m == 0)         tag = "R2 mode0";
              else if (m == 1 && ev == 3) tag = "R7 both";
              else if (m == 1 && ev == 2) tag = "R4 end";
              else if (m == 1)         tag = "R3 unit";
              else if (m == 2)         tag = "R5 unit only";
              else                     tag = "R6 end only";
              if (raw[s] && exp[s] && m != 0) tag = {tag, " R9 self"};
              @(negedge clk);
              check(tag, link_req, exp);
              check("R11 combine", chan_req, periph | exp);
              unit = '0; zero = '0;
              @(negedge clk);
              check("R8 one cycle / R10 not stored", link_req, '0);
            end
          end
        end
      end
    end

    // R8: several sources converge on target 2 and one also hits target 0
    clear_cfg();
    mode[0] = 2'd2; t1[0] = 2'd2;
    mode[1] = 2'd3; t1[1] = 2'd2;
    mode[3] = 2'd1; t1[3] = 2'd2; t2[3] = 2'd0;
    unit = 4'b1001; zero = 4'b1010;
    @(negedge clk);
    check("R8 OR merge", link_req, 4'b0101);
    unit = '0; zero = '0;
    @(negedge clk);
    check("R8 pulse ends", link_req, '0);

    // R10: blocked while disabled, nothing shows after enable returns
    clear_cfg();
    mode[1] = 2'd2; t1[1] = 2'd3;
    en = 4'b0111; unit[1] = 1'b1;
    @(negedge clk);
    check("R10 blocked", link_req, '0);
    unit = '0; en = '1;
    @(negedge clk);
    check("R10 dropped", link_req, '0);
    @(negedge clk);
    check("R10 still dropped", link_req, '0);

    // R9: self link repeated over back-to-back units
    clear_cfg();
    mode[2] = 2'd2; t1[2] = 2'd2; unit[2] = 1'b1;
    @(negedge clk);
    check("R9 self 1", link_req, 4'b0100);
    @(negedge clk);
    check("R9 self 2", link_req, 4'b0100);
    unit = '0;
    @(negedge clk);
    check("R9 self end", link_req, '0);

    // R1: reset clears a pending request
    unit[2] = 1'b1;
    @(negedge clk);
    unit = '0; rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", link_req, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule